// File: doc/BRIEF.md
# Banked ROM Window with Shared SRAM

This block decodes a 16-bit, byte-wide CPU bus for one cartridge slot. It opens two 8 KB windows. The lower window, at 0x4000-0x5FFF, shows one 8 KB bank of an external banked ROM. The upper window, at 0x6000-0x7FFF, shows an external 8 KB battery-backed SRAM. No dedicated bank register is visible to the CPU. The bank number is the low nibble of the SRAM byte at window offset 0x1FC4, and the CPU changes the bank by storing to that SRAM location at 0x7FC4.

A 16-byte I/O area at 0x7FC0-0x7FCF lies inside the SRAM window. Reads there return fixed or status values instead of memory, except at offset 4, which reads the bank byte. Offset 6 reports an asynchronous firmware switch, which passes through a synchronizer first. Writes anywhere in the SRAM window, the I/O area included, go to SRAM. The block generates the ROM and SRAM addresses and the SRAM write strobe, and it registers the read data. Accesses outside both windows read as all ones and never write.

Top module: `rom_sram_window`

## Requirements
- R1: A read at 0x4000-0x5FFF returns `rom_data` while `rom_addr` = {3'b000, bank[3:0], bus_addr[12:0]}. The top three bits of `rom_addr` are always zero.
- R2: The bank is bits [3:0] of the byte most recently written to 0x7FC4. It applies from the access after that write. Bits [7:4] of the written byte do not change the bank. The bank is undefined until the first such write.
- R3: A read at 0x6000-0x7FFF outside 0x7FC0-0x7FCF returns the SRAM byte at offset bus_addr[12:0].
- R4: A read at 0x7FC4 returns the full SRAM byte at offset 0x1FC4, upper nibble included.
- R5: A read at 0x7FC6 returns 0xFB when the synchronized firmware switch is 1 and 0xFF when it is 0.
- R6: A read at any other address in 0x7FC0-0x7FCF returns 0xFF, whatever the SRAM holds there.
- R7: A write strobe at 0x6000-0x7FFF, the I/O area included, raises `sram_we` in that same cycle. In that cycle `sram_addr` = bus_addr[12:0] and `sram_wdata` = `bus_wdata`.
- R8: Reads below 0x4000 or at 0x8000 and above return 0xFF. Writes there leave `sram_we` low and do not change the bank.
- R9: `bus_rdata` changes only on the clock edge that samples `bus_rd` high with `bus_wr` low. It holds its value in every other cycle and is 0xFF after reset. When `bus_rd` and `bus_wr` are high together, the cycle is a write only.
- R10: The firmware switch passes through 2 flip-flops. A read sampled on the 1st or 2nd edge after a change shows the old value. A read sampled on the 3rd edge shows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, release synchronized outside the block |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| fw_switch | input | 1 | Asynchronous firmware switch level |
| rom_addr | output | 20 | Byte address into the ROM image |
| rom_data | input | 8 | ROM byte at `rom_addr`, valid in the same cycle |
| sram_addr | output | 13 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_we | output | 1 | SRAM write enable, stored on the clock edge |
| sram_rdata | input | 8 | SRAM byte at `sram_addr`, valid in the same cycle |

## Verification
The bench reads both window edges (0x4000, 0x5FFF, 0x6000, 0x7FFF) and the first address past each window. A decoder off by one bit would return ROM or SRAM data where 0xFF is due, or the reverse. It writes the bank byte and then reads ROM in the very next access. A bank register that updated late, or that took bits from the upper nibble, would point to the wrong ROM location. It stores data into I/O-area cells and reads them back. A design that let memory through there would return the stored bytes instead of 0xFF, and one that blocked those writes would fail the write-strobe checks. It toggles the switch and reads back to back across the synchronizer, so a stage too many or too few moves the 0xFB response by one access.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

  // Which source feeds the read-data register
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ROM  = 2'd1,
    SEL_SRAM = 2'd2,
    SEL_IO   = 2'd3
  } sel_e;

endpackage

// File: rtl/rsw_decode.sv
module rsw_decode
  import rsw_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WIN_W       = 13,
  parameter int ROM_WIN_IDX = 2,
  parameter int RAM_WIN_IDX = 3,
  parameter int IO_W        = 4,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'h7FC0
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic              in_ram_win,
  output logic [IO_W-1:0]   io_off
);

  localparam int HI_W  = ADDR_W - WIN_W;
  localparam int TAG_W = ADDR_W - IO_W;
  localparam logic [HI_W-1:0]  ROM_TAG = HI_W'(ROM_WIN_IDX);
  localparam logic [HI_W-1:0]  RAM_TAG = HI_W'(RAM_WIN_IDX);
  localparam logic [TAG_W-1:0] IO_TAG  = IO_BASE[ADDR_W-1:IO_W];

  logic in_rom_win;
  logic in_io;

  always_comb begin
    in_rom_win = (addr[ADDR_W-1:WIN_W] == ROM_TAG);
    in_ram_win = (addr[ADDR_W-1:WIN_W] == RAM_TAG);
    in_io      = in_ram_win && (addr[ADDR_W-1:IO_W] == IO_TAG);
    io_off     = addr[IO_W-1:0];
    if (in_rom_win)      sel = SEL_ROM;
    else if (in_io)      sel = SEL_IO;
    else if (in_ram_win) sel = SEL_SRAM;
    else                 sel = SEL_NONE;
  end

endmodule

// File: rtl/rsw_bank_snoop.sv
module rsw_bank_snoop #(
  parameter int WIN_W  = 13,
  parameter int BANK_W = 4,
  parameter int DATA_W = 8,
  parameter logic [WIN_W-1:0] BANK_OFF = 13'h1FC4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [WIN_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BANK_W-1:0] bank
);

  // Copy of the bank nibble, refreshed whenever the CPU stores to
  // the SRAM cell that holds it. No reset: the bank starts undefined.
  logic              hit;
  logic [BANK_W-1:0] bank_d;
  logic [BANK_W-1:0] bank_q;

  always_comb begin
    hit    = wr_en && (wr_off == BANK_OFF);
    bank_d = wr_data[BANK_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (hit) bank_q <= bank_d;
  end

  assign bank = bank_q;

endmodule

// File: rtl/rsw_sync.sv
module rsw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_async;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rsw_rdata.sv
module rsw_rdata
  import rsw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IO_W   = 4,
  parameter logic [IO_W-1:0]   IO_BANK_IDX = 4'd4,
  parameter logic [IO_W-1:0]   IO_SW_IDX   = 4'd6,
  parameter logic [DATA_W-1:0] SW_ON_VAL   = 8'hFB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  sel_e              sel,
  input  logic [IO_W-1:0]   io_off,
  input  logic              sw_sync,
  input  logic [DATA_W-1:0] rom_data,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] IDLE_VAL = '1;

  logic [DATA_W-1:0] io_val;
  logic [DATA_W-1:0] mux_val;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    if (io_off == IO_BANK_IDX)    io_val = sram_rdata;
    else if (io_off == IO_SW_IDX) io_val = sw_sync ? SW_ON_VAL : IDLE_VAL;
    else                          io_val = IDLE_VAL;

    unique case (sel)
      SEL_ROM:  mux_val = rom_data;
      SEL_SRAM: mux_val = sram_rdata;
      SEL_IO:   mux_val = io_val;
      default:  mux_val = IDLE_VAL;
    endcase

    rdata_d = rd_en ? mux_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= IDLE_VAL;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/rom_sram_window.sv
module rom_sram_window
  import rsw_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int WIN_W       = 13,
  parameter int BANK_W      = 4,
  parameter int ROM_AW      = 20,
  parameter int ROM_WIN_IDX = 2,
  parameter int RAM_WIN_IDX = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] IO_BASE  = 16'h7FC0,
  parameter logic [WIN_W-1:0]  BANK_OFF = 13'h1FC4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fw_switch,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic [WIN_W-1:0]  sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  output logic              sram_we,
  input  logic [DATA_W-1:0] sram_rdata
);

  localparam int IO_W  = 4;
  localparam int PAD_W = ROM_AW - BANK_W - WIN_W;
  localparam logic [IO_W-1:0] IO_BANK_IDX = BANK_OFF[IO_W-1:0];
  localparam logic [IO_W-1:0] IO_SW_IDX   = IO_BANK_IDX + IO_W'(2);

  sel_e              sel;
  logic              in_ram_win;
  logic [IO_W-1:0]   io_off;
  logic              ram_wr;
  logic              rd_en;
  logic [BANK_W-1:0] bank;
  logic              sw_sync;

  rsw_decode #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .ROM_WIN_IDX(ROM_WIN_IDX),
    .RAM_WIN_IDX(RAM_WIN_IDX), .IO_W(IO_W), .IO_BASE(IO_BASE)
  ) u_decode (
    .addr(bus_addr), .sel(sel), .in_ram_win(in_ram_win), .io_off(io_off)
  );

  // A write wins over a read in the same cycle
  always_comb begin
    ram_wr = bus_wr && in_ram_win;
    rd_en  = bus_rd && !bus_wr;
  end

  rsw_bank_snoop #(
    .WIN_W(WIN_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .BANK_OFF(BANK_OFF)
  ) u_bank (
    .clk(clk), .wr_en(ram_wr), .wr_off(bus_addr[WIN_W-1:0]),
    .wr_data(bus_wdata), .bank(bank)
  );

  rsw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(fw_switch), .q(sw_sync)
  );

  rsw_rdata #(
    .DATA_W(DATA_W), .IO_W(IO_W), .IO_BANK_IDX(IO_BANK_IDX),
    .IO_SW_IDX(IO_SW_IDX), .SW_ON_VAL(8'hFB)
  ) u_rdata (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(sel), .io_off(io_off),
    .sw_sync(sw_sync), .rom_data(rom_data), .sram_rdata(sram_rdata),
    .rdata(bus_rdata)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rom_addr = {{PAD_W{1'b0}}, bank, bus_addr[WIN_W-1:0]};
    end else begin : g_nopad
      assign rom_addr = {bank, bus_addr[WIN_W-1:0]};
    end
  endgenerate

  assign sram_addr  = bus_addr[WIN_W-1:0];
  assign sram_wdata = bus_wdata;
  assign sram_we    = ram_wr;

endmodule

// File: rtl/rsw_checker.sv
module rsw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [7:0]  bus_rdata,
  input logic [19:0] rom_addr,
  input logic        sram_we
);

  // R2: bank nibble reaches the ROM address on the access after the store
  a_r2_bank_follows_store: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == 16'h7FC4) |-> rom_addr[16:13] == $past(bus_wdata[3:0]));

  // R9: read data only moves after a sampled read
  a_r9_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd && !bus_wr) |-> $stable(bus_rdata));

  // R8: reads outside both windows give all ones
  a_r8_outside_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && !bus_wr && (bus_addr < 16'h4000 || bus_addr >= 16'h8000))
      |-> bus_rdata == 8'hFF);

  // R8: no SRAM store without a write strobe
  a_r8_we_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> bus_wr);

  // R6: I/O cells other than 4 and 6 read all ones
  a_r6_io_other_ff: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && !bus_wr && bus_addr[15:4] == 12'h7FC &&
          bus_addr[3:0] != 4'd4 && bus_addr[3:0] != 4'd6) |-> bus_rdata == 8'hFF);

  // R5: switch cell reads only one of two values
  a_r5_switch_codes: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && !bus_wr && bus_addr == 16'h7FC6)
      |-> (bus_rdata == 8'hFB || bus_rdata == 8'hFF));

  // R1: upper ROM address bits stay zero
  a_r1_rom_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr[19:17] == 3'b000);

endmodule

bind rom_sram_window rsw_checker u_rsw_checker (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
  .rom_addr(rom_addr), .sram_we(sram_we)
);

// File: tb/rom_sram_window_tb_top.sv
module rom_sram_window_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;

  logic        clk;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_rd;
  logic        bus_wr;
  logic [7:0]  bus_rdata;
  logic        fw_switch;
  logic [19:0] rom_addr;
  logic [7:0]  rom_data;
  logic [12:0] sram_addr;
  logic [7:0]  sram_wdata;
  logic        sram_we;
  logic [7:0]  sram_rdata;

  int errors = 0;
  int checks = 0;

  rom_sram_window dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .fw_switch(fw_switch), .rom_addr(rom_addr), .rom_data(rom_data),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
    .sram_rdata(sram_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ROM image: a pattern computed from the full 20-bit address
  function automatic logic [7:0] rom_byte(input logic [19:0] a);
    return (a[7:0] + 8'(a[16:13]) * 8'd29) ^ {a[12:8], 3'b101} ^ {a[19:17], 5'b0};
  endfunction
  assign rom_data = rom_byte(rom_addr);

  // SRAM model: sparse store, written on the clock edge
  logic [7:0] mem [int];
  int mem_ver = 0;
  always @(posedge clk) begin
    if (sram_we) begin
      mem[int'(sram_addr)] = sram_wdata;
      mem_ver++;
    end
  end
  always @(sram_addr, mem_ver) begin
    sram_rdata = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
  end

  // Scoreboard
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd && !bus_wr;

  always @(negedge clk) begin
    if (rst_n && rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), {24'h0, bus_rdata}, {24'h0, exp_q.pop_front()});
    end
  end

  // Expected state tracked from the requirements
  logic [3:0] exp_bank;

  function automatic logic [7:0] exp_rom(input logic [12:0] off);
    return rom_byte({3'b000, exp_bank, off});
  endfunction

  // Drivers: each starts and ends at a falling edge
  task automatic bus_read(input logic [15:0] a, input logic [7:0] e, input string tag);
    bus_addr = a;
    bus_rd   = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input string tag);
    logic in_win;
    in_win    = (a[15:13] == 3'b011);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    #1;
    check({tag, " we"}, {31'h0, sram_we}, {31'h0, in_win});
    if (in_win) begin
      check({tag, " addr"}, {19'h0, sram_addr}, {19'h0, a[12:0]});
      check({tag, " data"}, {24'h0, sram_wdata}, {24'h0, d});
      if (a == 16'h7FC4) exp_bank = d[3:0];
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    fw_switch = 1'b0; exp_bank = '0;
    idle(3);
    check("R9 reset rdata", {24'h0, bus_rdata}, 32'hFF);
    rst_n = 1'b1;
    idle(2);

    // R1/R2/R4: bank from stored byte, full byte reads back
    bus_write(16'h7FC4, 8'hA3, "R7 bank store");
    bus_read(16'h4123, exp_rom(13'h0123), "R1 R2 rom bank 3");
    bus_read(16'h7FC4, 8'hA3, "R4 bank byte readback");
    check("R1 rom top bits", {12'h0, rom_addr[19:17]}, 0);

    // R9: hold while idle with a new address on the bus
    bus_addr = 16'h4000;
    idle(3);
    check("R9 hold", {24'h0, bus_rdata}, 32'hA3);

    // R2: store then ROM read on the very next access; window edges
    bus_write(16'h7FC4, 8'h5F, "R7 bank store");
    bus_read(16'h5FFF, exp_rom(13'h1FFF), "R1 R2 rom top edge bank F");
    bus_read(16'h4000, exp_rom(13'h0000), "R1 rom bottom edge");

    // R2: upper nibble has no effect on the mapping
    bus_write(16'h7FC4, 8'h05, "R7 bank store");
    bus_read(16'h4A5A, rom_byte({3'b000, 4'h5, 13'h0A5A}), "R2 bank 5");
    bus_write(16'h7FC4, 8'hC5, "R7 bank store");
    bus_read(16'h4A5A, rom_byte({3'b000, 4'h5, 13'h0A5A}), "R2 upper nibble ignored");
    bus_read(16'h7FC4, 8'hC5, "R4 upper nibble kept");

    // R3: SRAM window and its edges
    bus_write(16'h6000, 8'h11, "R7 sram low");
    bus_write(16'h7FFF, 8'h22, "R7 sram high");
    bus_write(16'h7FBF, 8'h33, "R7 sram below io");
    bus_write(16'h7FD0, 8'h44, "R7 sram above io");
    bus_read(16'h6000, 8'h11, "R3 sram low edge");
    bus_read(16'h7FFF, 8'h22, "R3 sram high edge");
    bus_read(16'h7FBF, 8'h33, "R3 below io");
    bus_read(16'h7FD0, 8'h44, "R3 above io");

    // R6/R7: stores into I/O cells still reach SRAM, reads give FF
    bus_write(16'h7FC0, 8'h5A, "R7 io store");
    bus_write(16'h7FCF, 8'h6B, "R7 io store");
    bus_read(16'h7FC0, 8'hFF, "R6 io cell 0");
    bus_read(16'h7FCF, 8'hFF, "R6 io cell F");
    bus_read(16'h7FC5, 8'hFF, "R6 io cell 5");

    // R5/R10: switch through the synchronizer
    bus_read(16'h7FC6, 8'hFF, "R5 switch off");
    fw_switch = 1'b1;
    bus_read(16'h7FC6, 8'hFF, "R10 edge 1 old value");
    bus_read(16'h7FC6, 8'hFF, "R10 edge 2 old value");
    bus_read(16'h7FC6, 8'hFB, "R10 R5 edge 3 new value");
    fw_switch = 1'b0;
    idle(SYNC + 1);
    bus_read(16'h7FC6, 8'hFF, "R5 switch off again");

    // R8: outside both windows
    bus_read(16'h3FFF, 8'hFF, "R8 below rom");
    bus_read(16'h8000, 8'hFF, "R8 above sram");
    bus_read(16'h0000, 8'hFF, "R8 zero");
    bus_write(16'h8000, 8'h07, "R8 write above");
    bus_write(16'h3FC4, 8'h0A, "R8 write below");
    bus_write(16'hFFC4, 8'h0B, "R8 write alias");
    bus_read(16'h4A5A, rom_byte({3'b000, 4'h5, 13'h0A5A}), "R8 bank untouched");

    // R9: read and write together is a write only
    bus_read(16'h6000, 8'h11, "R9 before combined");
    bus_addr = 16'h6000; bus_wdata = 8'h99; bus_rd = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check("R9 combined keeps rdata", {24'h0, bus_rdata}, 32'h11);
    bus_read(16'h6000, 8'h99, "R9 combined stored");

    idle(3);
    check("scoreboard drained", exp_q.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule